// File: doc/BRIEF.md
# Cross-Coupled Boot Strap Controller

This block is a cycle-level model of the two-transistor network that lets a host's serial modem-control lines reset a microcontroller and choose how it boots. Its inputs are the hardware levels of the two control lines, DTR and RTS. Both lines are active low: when the host asserts a line, that wire sits at logic 0. From these levels the network makes two pull-downs. One pull-down acts on the chip enable and the other acts on the boot-select strap. A pull-down is active only when the two lines differ. When the lines agree, neither node is driven, so application logic can use the strap pin.

The enable node has an RC charge time, which is modelled as a cycle counter. When enable is released, the chip sees it rise only after that delay. This gap is what makes the download entry work. The host goes straight from "enable pulled low" to "strap pulled low", so the strap is already low when the delayed enable finally rises. A sampler catches the strap level on that rising edge. It then raises a one-cycle boot pulse and a mode bit that says whether the chip runs its application or its serial loader.

Top module: `boot_strap_ctrl`

## Requirements
- R1: The line inputs are hardware levels, where 0 means the host asserted the line. With rts_n=0 and dtr_n=1, en_pulldown=1 and strap_pulldown=0.
- R2: With dtr_n=0 and rts_n=1, strap_pulldown=1 and en_pulldown=0. While this holds, strap_level is 0.
- R3: With dtr_n equal to rts_n, both pull-downs are 0. strap_level then equals app_strap_val when app_strap_oe=1, and is 1 (pull-up) otherwise.
- R4: The strap pull-down has priority over the application strap drive. With app_strap_oe=1 and app_strap_val=1, strap_level is still 0 whenever strap_pulldown=1.
- R5: en_delayed goes to 1 after CHARGE_CYCLES consecutive clock edges at which en_pulldown is 0. Any edge at which en_pulldown is 1 clears it and restarts the count.
- R6: On the clock edge after en_delayed rises, boot_pulse is 1 for exactly one cycle. boot_download is loaded with the inverse of strap_level as seen during the cycle in which en_delayed first reads 1 (0 = normal application, 1 = serial download). boot_download holds its value until the next boot pulse.
- R7: chip_reset is 1 whenever en_delayed is 0. It is 1 during and right after any enable pull-down.
- R8: After reset, en_delayed=0, chip_reset=1, boot_pulse=0 and boot_download=0.
- R9: A direct swap from (rts_n=0, dtr_n=1) to (rts_n=1, dtr_n=0), held past the charge time, boots in download mode. If the strap pull-down is released before the charge time ends, the boot is normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dtr_n | input | 1 | DTR hardware level (0 = asserted) |
| rts_n | input | 1 | RTS hardware level (0 = asserted) |
| app_strap_oe | input | 1 | Application drives the strap when 1 |
| app_strap_val | input | 1 | Strap value driven by the application |
| en_pulldown | output | 1 | Network pulls the enable node low |
| strap_pulldown | output | 1 | Network pulls the strap node low |
| strap_level | output | 1 | Resolved strap level |
| en_delayed | output | 1 | Enable level after the charge delay |
| chip_reset | output | 1 | Chip held in reset |
| boot_pulse | output | 1 | One-cycle pulse when the chip starts |
| boot_download | output | 1 | Boot mode: 1 = serial download, 0 = normal |

## Verification
The assertions check the following on every cycle:
- the strap pull-down dominates the strap level;
- an enable pull-down always forces reset on the next cycle;
- the delayed enable never rises straight out of a pull-down;
- each rise of the delayed enable produces exactly one boot pulse, carrying the inverse of the strap seen at the rise.

The exact length of the charge window is shown only by the bench's scenarios. The same holds for restarting the count on a short glitch, and for the contrast between a fast swap and a slow swap. For these, the bench counts edges from each line change and predicts the mode of each boot.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

  typedef struct packed {
    logic en_pd;
    logic strap_pd;
  } pulldown_t;

  // Two-transistor network: a pull-down is active only when the lines disagree.
  function automatic pulldown_t net_decode(input logic dtr_lvl, input logic rts_lvl);
    pulldown_t r;
    r.en_pd    = (rts_lvl == 1'b0) && (dtr_lvl == 1'b1);
    r.strap_pd = (dtr_lvl == 1'b0) && (rts_lvl == 1'b1);
    return r;
  endfunction

  // Strap node: network pull-down > application drive > pull-up.
  function automatic logic strap_resolve(input logic pd, input logic oe, input logic val);
    if (pd)      return 1'b0;
    else if (oe) return val;
    else         return 1'b1;
  endfunction

endpackage

// File: rtl/bsc_pulldown_net.sv
module bsc_pulldown_net
  import bsc_pkg::*;
(
  input  logic dtr_n,
  input  logic rts_n,
  input  logic app_strap_oe,
  input  logic app_strap_val,
  output logic en_pd,
  output logic strap_pd,
  output logic strap_lvl
);
  pulldown_t pd;

  always_comb begin
    pd        = net_decode(dtr_n, rts_n);
    en_pd     = pd.en_pd;
    strap_pd  = pd.strap_pd;
    strap_lvl = strap_resolve(pd.strap_pd, app_strap_oe, app_strap_val);
  end
endmodule

// File: rtl/bsc_charge_timer.sv
module bsc_charge_timer #(
  parameter int CHARGE_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_low,
  output logic en_late
);
  localparam int CNT_W = $clog2(CHARGE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CHARGE_CYCLES);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (hold_low)      cnt <= '0;
    else if (cnt != LIMIT)  cnt <= cnt + 1'b1;
  end

  assign en_late = (cnt == LIMIT);
endmodule

// File: rtl/bsc_boot_sampler.sv
module bsc_boot_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic en_late,
  input  logic strap_lvl,
  output logic en_rise,
  output logic pulse,
  output logic download
);
  logic en_q;

  assign en_rise = en_late & ~en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      pulse    <= 1'b0;
      download <= 1'b0;
    end else begin
      en_q  <= en_late;
      pulse <= en_rise;
      if (en_rise) download <= ~strap_lvl;
    end
  end
endmodule

// File: rtl/boot_strap_ctrl.sv
module boot_strap_ctrl #(
  parameter int CHARGE_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dtr_n,
  input  logic rts_n,
  input  logic app_strap_oe,
  input  logic app_strap_val,
  output logic en_pulldown,
  output logic strap_pulldown,
  output logic strap_level,
  output logic en_delayed,
  output logic chip_reset,
  output logic boot_pulse,
  output logic boot_download
);
  logic en_rise;

  bsc_pulldown_net i_net (
    .dtr_n         (dtr_n),
    .rts_n         (rts_n),
    .app_strap_oe  (app_strap_oe),
    .app_strap_val (app_strap_val),
    .en_pd         (en_pulldown),
    .strap_pd      (strap_pulldown),
    .strap_lvl     (strap_level)
  );

  bsc_charge_timer #(.CHARGE_CYCLES(CHARGE_CYCLES)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold_low (en_pulldown),
    .en_late  (en_delayed)
  );

  bsc_boot_sampler i_samp (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_late   (en_delayed),
    .strap_lvl (strap_level),
    .en_rise   (en_rise),
    .pulse     (boot_pulse),
    .download  (boot_download)
  );

  assign chip_reset = ~en_delayed;
endmodule

// File: rtl/bsc_chk.sv
module bsc_chk (
  input logic clk,
  input logic rst_n,
  input logic en_pulldown,
  input logic strap_pulldown,
  input logic strap_level,
  input logic en_delayed,
  input logic chip_reset,
  input logic boot_pulse,
  input logic boot_download
);
  // R4
  strap_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strap_pulldown |-> !strap_level);

  // R7
  pulldown_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_pulldown |=> chip_reset);

  // R5
  no_early_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_delayed) |-> !$past(en_pulldown));

  // R6
  boot_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_delayed) |=> boot_pulse && (boot_download == !$past(strap_level)));

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boot_pulse |=> !boot_pulse);

  // R1
  net_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_pulldown && strap_pulldown));
endmodule

bind boot_strap_ctrl bsc_chk i_bsc_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .en_pulldown    (en_pulldown),
  .strap_pulldown (strap_pulldown),
  .strap_level    (strap_level),
  .en_delayed     (en_delayed),
  .chip_reset     (chip_reset),
  .boot_pulse     (boot_pulse),
  .boot_download  (boot_download)
);

// File: tb/test_boot_strap_ctrl.sv
module test_boot_strap_ctrl;
  localparam int CHG = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dtr_n = 1'b1, rts_n = 1'b1, app_strap_oe = 1'b0, app_strap_val = 1'b0;
  logic en_pulldown, strap_pulldown, strap_level, en_delayed, chip_reset;
  logic boot_pulse, boot_download;

  int vectors = 0;
  int errors  = 0;
  bit exp_q[$];
  bit done = 1'b0;

  always #5 clk = ~clk;

  boot_strap_ctrl #(.CHARGE_CYCLES(CHG)) i_boot_strap_ctrl (
    .clk(clk), .rst_n(rst_n), .dtr_n(dtr_n), .rts_n(rts_n),
    .app_strap_oe(app_strap_oe), .app_strap_val(app_strap_val),
    .en_pulldown(en_pulldown), .strap_pulldown(strap_pulldown),
    .strap_level(strap_level), .en_delayed(en_delayed), .chip_reset(chip_reset),
    .boot_pulse(boot_pulse), .boot_download(boot_download)
  );

  task automatic check(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic lines(input logic d, input logic r);
    dtr_n = d;
    rts_n = r;
  endtask

  // Scoreboard monitor: each boot pulse pops one expected mode.
  always @(negedge clk) begin
    if (rst_n && boot_pulse) begin
      vectors++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R6: actual unexpected boot pulse (mode %b) expected none", boot_download);
      end else begin
        bit e;
        e = exp_q.pop_front();
        if (boot_download !== e) begin
          errors++;
          $display("FAIL R6/R9: actual mode %b expected %b", boot_download, e);
        end
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    cycles(3);
    // R8 reset state
    check("R8 en_delayed", en_delayed, 1'b0);
    check("R8 chip_reset", chip_reset, 1'b1);
    check("R8 boot_pulse", boot_pulse, 1'b0);
    check("R8 boot_download", boot_download, 1'b0);
    // R3 lines equal high, no app drive
    check("R3 en_pulldown", en_pulldown, 1'b0);
    check("R3 strap pull-up", strap_level, 1'b1);

    // Power-on boot: normal
    exp_q.push_back(1'b0);
    rst_n = 1'b1;
    cycles(CHG - 1);
    check("R5 still charging", en_delayed, 1'b0);
    check("R7 held in reset", chip_reset, 1'b1);
    cycles(1);
    check("R5 enable risen", en_delayed, 1'b1);
    check("R7 released", chip_reset, 1'b0);
    cycles(2);
    check("R6 pulse one cycle", boot_pulse, 1'b0);

    // R1 enable pull-down
    lines(1'b1, 1'b0);
    #1;
    check("R1 en_pulldown", en_pulldown, 1'b1);
    check("R1 strap_pulldown", strap_pulldown, 1'b0);
    cycles(1);
    check("R7 reset on pulldown", chip_reset, 1'b1);
    cycles(2);
    // release to both-low, normal boot
    exp_q.push_back(1'b0);
    lines(1'b0, 1'b0);
    #1;
    check("R3 both low no pulldown", en_pulldown | strap_pulldown, 1'b0);
    cycles(CHG + 4);

    // R2 and R9 fast swap -> download
    lines(1'b1, 1'b0);
    cycles(3);
    exp_q.push_back(1'b1);
    lines(1'b0, 1'b1);
    #1;
    check("R2 strap_pulldown", strap_pulldown, 1'b1);
    check("R2 en_pulldown", en_pulldown, 1'b0);
    check("R2 strap low", strap_level, 1'b0);
    app_strap_oe = 1'b1; app_strap_val = 1'b1;
    #1;
    check("R4 pull-down beats app", strap_level, 1'b0);
    cycles(CHG + 3);
    check("R9 download mode", boot_download, 1'b1);
    lines(1'b1, 1'b1);
    #1;
    check("R3 app strap drives", strap_level, 1'b1);
    app_strap_oe = 1'b0;
    cycles(2);

    // R9 slow swap: strap released before charge ends -> normal
    lines(1'b1, 1'b0);
    cycles(2);
    exp_q.push_back(1'b0);
    lines(1'b0, 1'b1);
    cycles(3);
    lines(1'b1, 1'b1);
    cycles(CHG + 3);
    check("R9 normal after slow swap", boot_download, 1'b0);

    // R5 glitch restarts count
    lines(1'b1, 1'b0);
    cycles(2);
    lines(1'b1, 1'b1);
    cycles(CHG - 3);
    lines(1'b1, 1'b0);
    cycles(1);
    exp_q.push_back(1'b1);
    lines(1'b1, 1'b1);
    app_strap_oe = 1'b1; app_strap_val = 1'b0;
    cycles(CHG - 1);
    check("R5 count restarted", en_delayed, 1'b0);
    cycles(1);
    check("R5 rise after full window", en_delayed, 1'b1);
    cycles(3);
    check("R3 app strap low boots download", boot_download, 1'b1);
    app_strap_oe = 1'b0;
    cycles(3);

    vectors++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R6: actual %0d boots missing expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule